// File: doc/BRIEF.md
# Receive Frame Checker with Commit FIFO

This block sits at the receiving end of a serial radio link. One path takes the raw bit stream from the demodulator and removes the additive scrambling. It does this by XOR with a local pseudo-random sequence that restarts at every frame start. The descrambled bits go out to an external error-correction decoder, which this block does not contain.

The decoded bytes come back to the block with valid and last flags. Each byte is written into a frame FIFO and fed to a CRC-32 engine in the same cycle. The CRC covers the whole frame, including its four-byte checksum trailer, so a correct frame leaves a zero remainder.

The FIFO holds each frame speculatively. A working write pointer advances as bytes arrive, while a separate committed pointer marks what the host may read:
- **Good frame:** the committed pointer jumps forward over the payload, and a ready pulse reports the payload length.
- **Bad frame** (wrong checksum, too short, or arriving into a full FIFO): the working pointer is wound back, and the frame never reaches the host.

After every frame end, the CRC, the byte count and the overflow state return to their starting values.

Top module: `rxf_frame_checker`

## Requirements
- R1: `dsc_bit` equals `ser_bit` XOR a key bit, registered one cycle after the input, with `dsc_vld` following `ser_en` one cycle later. The key comes from a 7-bit state s: key = s[6] XOR s[5]. After each enabled bit the state becomes {s[5:0], key}.
- R2: A bit presented with `ser_en` and `ser_sof` both high uses the all-ones state. Because key = 1 XOR 1 = 0 for that state, such a bit passes through unchanged. The state advances only on enabled bits.
- R3: The CRC starts at 0xFFFFFFFF and uses polynomial 0x04C11DB7. Each byte is shifted in MSB first, with no reflection and no final inversion. A frame is checksum-correct when the register is zero after all bytes have been shifted in. This happens when the trailer is the remainder of the payload, most significant byte first.
- R4: A good frame produces a one-cycle `frame_ready` in the cycle after its last byte is accepted. `frame_len` then holds the payload byte count (total bytes minus 4). The payload becomes readable in arrival order, and the trailer is never readable.
- R5: A frame whose checksum is wrong produces a one-cycle `frame_bad` in the cycle after its last byte. None of its bytes ever become readable.
- R6: A frame of fewer than 5 bytes is bad, whatever its content.
- R7: A byte is dropped when the working occupancy equals DEPTH, judged on the state before this cycle's read. The frame it belongs to is then bad, and the space taken by the frame is recovered.
- R8: `rd_avail` reflects committed bytes only. Bytes of a frame still in flight keep it low.
- R9: While `rd_avail` is high, `rd_data` shows the oldest committed byte, and `rd_en` removes it. `rd_en` has no effect while `rd_avail` is low.
- R10: After each frame end, the CRC, the byte count and the overflow state are cleared. The verdict on one frame does not depend on earlier frames.
- R11: A host read and a frame commit in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_bit | input | 1 | Scrambled bit from the demodulator |
| ser_en | input | 1 | Qualifies ser_bit |
| ser_sof | input | 1 | Marks the first bit of a frame |
| dsc_bit | output | 1 | Descrambled bit |
| dsc_vld | output | 1 | Qualifies dsc_bit |
| byte_data | input | 8 | Decoded byte |
| byte_vld | input | 1 | Qualifies byte_data |
| byte_last | input | 1 | Marks the final byte of a frame |
| rd_en | input | 1 | Host pop request |
| rd_data | output | 8 | Oldest committed byte |
| rd_avail | output | 1 | Committed data present |
| frame_ready | output | 1 | One-cycle good-frame pulse |
| frame_bad | output | 1 | One-cycle dropped-frame pulse |
| frame_len | output | AW+1 | Payload length of the last good frame |

## Verification
The two functions that can collide are the host pop and the end of a frame. Both can fall in the same cycle: a commit moves the committed pointer while a read moves the read pointer. The bench provokes this by leaving a long frame committed and unread, then streaming a second frame while popping every cycle, so the last byte of the second frame coincides with a pop. Afterwards, every remaining byte must still come out once and in order, and `rd_avail` must match a byte queue kept in the bench.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam logic [31:0] CRC_POLY      = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_INIT      = 32'hFFFF_FFFF;
    localparam int          TRAILER_BYTES = 4;

    // Shift one byte, MSB first, through the CRC register
    function automatic logic [31:0] crc32_byte(input logic [31:0] c,
                                               input logic [7:0]  d);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[31] ^ d[i];
            r  = {r[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
        end
        return r;
    endfunction

endpackage

// File: rtl/rxf_descrambler.sv
module rxf_descrambler #(
    parameter int W     = 7,
    parameter int TAP_A = 6,
    parameter int TAP_B = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    input  logic en_i,
    input  logic sof_i,
    output logic bit_o,
    output logic vld_o
);
    typedef struct packed {
        logic [W-1:0] lfsr;
        logic         bit_r;
        logic         vld;
    } st_t;

    st_t          st_d, st_q;
    logic [W-1:0] cur;
    logic         key;

    always_comb begin
        st_d     = st_q;
        cur      = sof_i ? {W{1'b1}} : st_q.lfsr;
        key      = cur[TAP_A] ^ cur[TAP_B];
        st_d.vld = en_i;
        if (en_i) begin
            st_d.bit_r = bit_i ^ key;
            st_d.lfsr  = {cur[W-2:0], key};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{lfsr: {W{1'b1}}, bit_r: 1'b0, vld: 1'b0};
        else        st_q <= st_d;
    end

    assign bit_o = st_q.bit_r;
    assign vld_o = st_q.vld;

    // R1
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> vld_o);
    // R2
    sof_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && sof_i) |=> (bit_o == $past(bit_i)));
endmodule

// File: rtl/rxf_crc32.sv
module rxf_crc32 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step_i,
    input  logic        clear_i,
    input  logic [7:0]  data_i,
    output logic [31:0] crc_next_o
);
    import rxf_pkg::*;

    logic [31:0] crc_d, crc_q;

    always_comb begin
        crc_next_o = crc32_byte(crc_q, data_i);
        crc_d      = crc_q;
        if (clear_i)     crc_d = CRC_INIT;
        else if (step_i) crc_d = crc_next_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= CRC_INIT;
        else        crc_q <= crc_d;
    end

    // R10
    crc_reinit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (crc_q == CRC_INIT));
endmodule

// File: rtl/rxf_frame_fifo.sv
module rxf_frame_fifo #(
    parameter int DEPTH = 16,
    parameter int TRAIL = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [7:0]   wr_data_i,
    input  logic         fin_good_i,
    input  logic         fin_bad_i,
    input  logic         rd_en_i,
    output logic [7:0]   rd_data_o,
    output logic         avail_o,
    output logic         full_o
);
    localparam logic [AW:0] DEPTH_P = (AW+1)'(DEPTH);
    localparam logic [AW:0] TRAIL_P = (AW+1)'(TRAIL);

    typedef struct packed {
        logic [AW:0] wptr;
        logic [AW:0] cptr;
        logic [AW:0] rptr;
    } ptr_t;

    ptr_t        p_d, p_q;
    logic [7:0]  mem [DEPTH];
    logic [AW:0] wnext;

    assign full_o    = (p_q.wptr - p_q.rptr) == DEPTH_P;
    assign avail_o   = p_q.cptr != p_q.rptr;
    assign rd_data_o = mem[p_q.rptr[AW-1:0]];

    always_comb begin
        p_d   = p_q;
        wnext = p_q.wptr + (AW+1)'(wr_i);
        if (rd_en_i && avail_o) p_d.rptr = p_q.rptr + 1'b1;
        if (fin_good_i) begin
            p_d.wptr = wnext - TRAIL_P;
            p_d.cptr = wnext - TRAIL_P;
        end else if (fin_bad_i) begin
            p_d.wptr = p_q.cptr;
        end else begin
            p_d.wptr = wnext;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (wr_i) mem[p_q.wptr[AW-1:0]] <= wr_data_i;
    end

    // R7
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.wptr - p_q.rptr) <= DEPTH_P);
    // R8
    commit_behind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.wptr - p_q.cptr) <= DEPTH_P);
    // R9
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !avail_o) |=> $stable(p_q.rptr));
endmodule

// File: rtl/rxf_frame_checker.sv
module rxf_frame_checker #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_bit,
    input  logic          ser_en,
    input  logic          ser_sof,
    output logic          dsc_bit,
    output logic          dsc_vld,
    input  logic [7:0]    byte_data,
    input  logic          byte_vld,
    input  logic          byte_last,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    output logic          rd_avail,
    output logic          frame_ready,
    output logic          frame_bad,
    output logic [AW:0]   frame_len
);
    import rxf_pkg::*;

    localparam logic [AW:0] TRAIL_P = (AW+1)'(TRAILER_BYTES);
    localparam logic [AW:0] MIN_CNT = (AW+1)'(TRAILER_BYTES + 1);

    typedef struct packed {
        logic [AW:0] cnt;
        logic        ovf;
        logic        rdy;
        logic        bad;
        logic [AW:0] len;
    } ctl_t;

    ctl_t        c_d, c_q;
    logic        full, acc, fin, good;
    logic [AW:0] cnt_n;
    logic        ovf_n;
    logic [31:0] crc_next;

    rxf_descrambler #(.W(7), .TAP_A(6), .TAP_B(5)) i_dsc (
        .clk(clk), .rst_n(rst_n), .bit_i(ser_bit), .en_i(ser_en),
        .sof_i(ser_sof), .bit_o(dsc_bit), .vld_o(dsc_vld));

    rxf_crc32 i_crc (
        .clk(clk), .rst_n(rst_n), .step_i(byte_vld), .clear_i(fin),
        .data_i(byte_data), .crc_next_o(crc_next));

    rxf_frame_fifo #(.DEPTH(DEPTH), .TRAIL(TRAILER_BYTES)) i_fifo (
        .clk(clk), .rst_n(rst_n), .wr_i(acc), .wr_data_i(byte_data),
        .fin_good_i(good), .fin_bad_i(fin && !good), .rd_en_i(rd_en),
        .rd_data_o(rd_data), .avail_o(rd_avail), .full_o(full));

    always_comb begin
        c_d   = c_q;
        acc   = byte_vld && !full;
        fin   = byte_vld && byte_last;
        cnt_n = c_q.cnt + (AW+1)'(acc);
        ovf_n = c_q.ovf | (byte_vld && full);
        good  = fin && !ovf_n && (crc_next == 32'h0) && (cnt_n >= MIN_CNT);
        c_d.rdy = good;
        c_d.bad = fin && !good;
        if (good) c_d.len = cnt_n - TRAIL_P;
        if (fin) begin
            c_d.cnt = '0;
            c_d.ovf = 1'b0;
        end else begin
            c_d.cnt = cnt_n;
            c_d.ovf = ovf_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign frame_ready = c_q.rdy;
    assign frame_bad   = c_q.bad;
    assign frame_len   = c_q.len;

    // R4
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_ready && frame_bad));
    // R4
    len_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ready |-> (frame_len >= (AW+1)'(1)));
    // R8
    avail_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_avail) |-> frame_ready);
    // R10
    count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> (c_q.cnt == '0 && !c_q.ovf));
endmodule

// File: tb/test_rxf_frame_checker.sv
module test_rxf_frame_checker;
    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_bit = 0, ser_en = 0, ser_sof = 0;
    logic dsc_bit, dsc_vld;
    logic [7:0] byte_data = 0;
    logic byte_vld = 0, byte_last = 0, rd_en = 0;
    logic [7:0] rd_data;
    logic rd_avail, frame_ready, frame_bad;
    logic [AW:0] frame_len;

    int n_cmp = 0, n_bad = 0;
    logic [7:0] fr [64];
    logic [7:0] q [$];

    always #4 clk = ~clk;

    rxf_frame_checker #(.DEPTH(DEPTH)) i_rxf_frame_checker (
        .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .ser_en(ser_en),
        .ser_sof(ser_sof), .dsc_bit(dsc_bit), .dsc_vld(dsc_vld),
        .byte_data(byte_data), .byte_vld(byte_vld), .byte_last(byte_last),
        .rd_en(rd_en), .rd_data(rd_data), .rd_avail(rd_avail),
        .frame_ready(frame_ready), .frame_bad(frame_bad),
        .frame_len(frame_len));

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++)
            for (int b = 7; b >= 0; b--) begin
                logic fb = c[31] ^ fr[i][b];
                c = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
            end
        return c;
    endfunction

    // Build an n-byte frame; n >= 5 gets a correct trailer
    task automatic build(input int n, input int seed);
        logic [31:0] c;
        if (n < 5) begin
            for (int i = 0; i < n; i++) fr[i] = 8'(seed + 3*i);
        end else begin
            for (int i = 0; i < n-4; i++) fr[i] = 8'(seed*31 + i*13 + 7);
            c = ref_crc(n-4);
            fr[n-4] = c[31:24]; fr[n-3] = c[23:16];
            fr[n-2] = c[15:8];  fr[n-1] = c[7:0];
        end
    endtask

    // One cycle on the byte interface; optional pop checked against the queue
    task automatic cycle_byte(input logic v, input logic [7:0] d, input logic l, input logic pop);
        chk(rd_avail == (q.size() != 0), "R8 avail", rd_avail, q.size() != 0);
        if (pop && rd_avail) begin
            chk(rd_data == q[0], "R11 rd_data", rd_data, q[0]);
            void'(q.pop_front());
            rd_en = 1'b1;
        end else rd_en = 1'b0;
        byte_vld = v; byte_data = d; byte_last = l;
        @(negedge clk);
        byte_vld = 0; byte_last = 0; rd_en = 0;
    endtask

    task automatic send_frame(input int n, input logic pop, input logic exp_good, input string tag);
        for (int i = 0; i < n; i++) cycle_byte(1'b1, fr[i], i == n-1, pop);
        chk(frame_ready == exp_good, {tag, " ready"}, frame_ready, exp_good);
        chk(frame_bad == !exp_good, {tag, " bad"}, frame_bad, !exp_good);
        if (exp_good) begin
            chk(frame_len == (AW+1)'(n-4), {tag, " len"}, frame_len, n-4);
            for (int i = 0; i < n-4; i++) q.push_back(fr[i]);
        end
        @(negedge clk);
        chk(!frame_ready && !frame_bad, {tag, " pulse"}, frame_ready, 0);
    endtask

    task automatic drain(input string tag);
        while (q.size() != 0) begin
            chk(rd_avail == 1'b1, {tag, " avail"}, rd_avail, 1);
            chk(rd_data == q[0], {tag, " data"}, rd_data, q[0]);
            void'(q.pop_front());
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
        chk(rd_avail == 1'b0, {tag, " empty"}, rd_avail, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [6:0] s;
        logic [6:0] cur;
        logic exp_b, exp_v, key;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(!rd_avail && !frame_ready && !frame_bad && !dsc_vld, "R9 reset", rd_avail, 0);

        // Descrambler sweep with gaps and two restarts (R1, R2)
        s = 7'h7F;
        for (int i = 0; i < 120; i++) begin
            ser_en  = (i % 3) != 2;
            ser_sof = (i == 0) || (i == 40) || (i == 81);
            ser_bit = ((i * 7 + 3) % 5) < 2;
            exp_v = ser_en;
            exp_b = exp_b;
            if (ser_en) begin
                cur   = ser_sof ? 7'h7F : s;
                key   = cur[6] ^ cur[5];
                exp_b = ser_bit ^ key;
                s     = {cur[5:0], key};
            end
            @(negedge clk);
            chk(dsc_vld == exp_v, "R1 dsc_vld", dsc_vld, exp_v);
            if (exp_v) chk(dsc_bit == exp_b, (ser_sof ? "R2 dsc_bit" : "R1 dsc_bit"), dsc_bit, exp_b);
        end
        ser_en = 0; ser_sof = 0;

        // Length sweep 1..17 (R3, R4, R6, R7)
        for (int n = 1; n <= 17; n++) begin
            build(n, n);
            send_frame(n, 1'b0, (n >= 5) && (n <= DEPTH), n < 5 ? "R6" : (n > DEPTH ? "R7" : "R4"));
            drain("R4 drain");
        end
        // space fully recovered after overflow (R7, R10)
        build(16, 99);
        send_frame(16, 1'b0, 1'b1, "R7 refill");
        drain("R7 drain");

        // Single-bit corruption at every bit of an 8-byte frame (R3, R5)
        for (int k = 0; k < 8; k++)
            for (int b = 0; b < 8; b++) begin
                build(8, 50 + k);
                fr[k][b] = ~fr[k][b];
                send_frame(8, 1'b0, 1'b0, "R5 corrupt");
                chk(rd_avail == 1'b0, "R5 nothing readable", rd_avail, 0);
            end
        build(8, 77);
        send_frame(8, 1'b0, 1'b1, "R10 after bad");
        drain("R10 drain");

        // Pop while empty is ignored (R9)
        rd_en = 1'b1; @(negedge clk); @(negedge clk); rd_en = 1'b0;
        build(6, 12);
        send_frame(6, 1'b0, 1'b1, "R9 post-empty");
        drain("R9 drain");

        // Pop coinciding with commit (R11), in-flight bytes hidden (R8)
        build(14, 21);
        send_frame(14, 1'b0, 1'b1, "R11 first");
        build(8, 22);
        send_frame(8, 1'b1, 1'b1, "R11 second");
        drain("R11 drain");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule